// File: doc/BRIEF.md
# Three-Source Vectored Interrupt Controller

This controller sits beside one processor core and turns three kinds of event into requests to insert a call-and-link instruction. The three events are a streamer event (a rollover or a block wrap), an edge on one selectable input pin, and a periodic timer tick. Each source has a fixed pair of vector registers. When the pipeline accepts an insert request, it saves the return address in the even register of the pair and jumps through the odd one.

Software configures the controller through three write ports: an 8-bit mode word, the timer period and the index of the watched pin. A global lock holds back new insertions. Software can set or clear the lock with two strobes. The lock is also set automatically when a source whose lock-on-entry bit is set is taken. It is cleared automatically when the core executes a jump whose target is one of the even vector registers, which is the interrupt return. Events that arrive while the lock is set are held as pending and are served later. Older pending events are served first. Events that become pending in the same cycle follow a fixed priority.

Top module: `tri_irq_ctrl`

## Requirements
- R1: After reset the mode word is zero, so every source is disabled, the lock is clear and `ins_req` is low. Streamer pulses arriving while the mode word is zero cause no request.
- R2: Mode bits [6:5] select the streamer source: 00 and 01 disable it, 10 takes rollover pulses and 11 takes block-wrap pulses. The pulse type that is not selected is ignored.
- R3: Mode bits [3:2] select the pin edge: 00 off, 01 either edge, 10 rising, 11 falling. The pin passes through a two-stage synchronizer, so a change sampled at clock edge k raises `ins_req` after edge k+2. Pins that are not selected have no effect.
- R4: Mode bit [0] enables the timer. With a period of P the timer becomes pending every P cycles, and a period of 0 behaves like 1. A period write reloads the count, so the next tick comes P cycles after the write edge.
- R5: Source IDs are 0 for the streamer, 1 for the pin and 2 for the timer. The link address is 0x1F0 + 2*ID and the target address is the link address + 1.
- R6: Each source has a sticky pending flag. It stays set until an insert request for that source is accepted, which happens when `ins_req` and `ins_ready` are both high at a clock edge.
- R7: Mode bits 7, 4 and 1 are the lock-on-entry bits of the streamer, pin and timer. When such a source is accepted, the lock is set. While the lock is set, `ins_req` stays low.
- R8: `lock_set` sets the lock and `lock_clr` clears it. When both are high in the same cycle, the set wins.
- R9: A valid jump to 0x1F0, 0x1F2 or 0x1F4 clears the lock. A jump to any other target, such as 0x1F1, leaves the lock unchanged.
- R10: Sources that become pending in the same cycle are served in the order streamer, pin, timer.
- R11: A source that became pending earlier is served before a source that became pending later, whatever their priority.
- R12: The pin index and the timer period can be rewritten while their sources are enabled, and the new value takes effect without a disable step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 8 | New mode word |
| per_we | input | 1 | Write strobe for the timer period |
| per_wdata | input | PER_W | New timer period |
| pin_we | input | 1 | Write strobe for the pin index |
| pin_wdata | input | PIN_W | New pin index |
| lock_set | input | 1 | Sets the global lock |
| lock_clr | input | 1 | Clears the global lock |
| pins_in | input | NUM_PINS | Asynchronous pin inputs |
| strm_rollover | input | 1 | Streamer rollover pulse |
| strm_wrap | input | 1 | Streamer block-wrap pulse |
| jmp_valid | input | 1 | A jump or link executes in this cycle |
| jmp_target | input | 9 | Register address that the jump targets |
| ins_ready | input | 1 | The pipeline accepts the insert request |
| ins_req | output | 1 | Request to insert a call-and-link |
| ins_src | output | 2 | ID of the source being served |
| ins_link_addr | output | 9 | Register that receives the return address |
| ins_tgt_addr | output | 9 | Register that holds the jump target |

## Verification
Two actions can fall in the same clock edge: an interrupt return that clears the lock, and the acceptance of a source whose lock-on-entry bit sets it again. The bench provokes this by asserting a jump to 0x1F0 in the same cycle as `ins_ready` while a streamer source with its lock bit set is requesting. It then judges the result by checking that a later event gets no request until `lock_clr` is pulsed. The same set-over-clear rule is checked with `lock_set` and `lock_clr` asserted together. Priority against arrival order is checked the same way. The timer, pin and streamer are timed to become pending on one edge, and a separate case makes a pin event pending before a streamer event.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int NSRC   = 3;
  localparam int IDX_W  = 2;
  localparam int ADDR_W = 9;
  localparam logic [ADDR_W-1:0] VEC_BASE = 9'h1F0;

  typedef enum logic [IDX_W-1:0] {
    SRC_STRM = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_TMR  = 2'd2
  } src_e;

  // mode word, bit 7 down to bit 0
  typedef struct packed {
    logic       lk_s;
    logic [1:0] s_sel;
    logic       lk_p;
    logic [1:0] p_sel;
    logic       lk_t;
    logic       t_en;
  } mode_t;
endpackage

// File: rtl/irq_timer.sv
module irq_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             per_we,
  input  logic [PER_W-1:0] per_wdata,
  output logic             fire
);
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] cnt_q, cnt_d;

  function automatic logic [PER_W-1:0] reload_of(input logic [PER_W-1:0] p);
    return (p == '0) ? '0 : p - PER_W'(1);
  endfunction

  always_comb begin
    per_d = per_we ? per_wdata : per_q;
    fire  = en && !per_we && (cnt_q == '0);
    if (per_we)
      cnt_d = reload_of(per_wdata);
    else if (!en || cnt_q == '0)
      cnt_d = reload_of(per_q);
    else
      cnt_d = cnt_q - PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
    end
  end

  // R4: a running count steps down by one each cycle
  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !per_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - PER_W'(1)));
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int NUM_PINS = 8,
  parameter int PIN_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [PIN_W-1:0]    sel,
  input  logic [1:0]          edge_mode,
  output logic                evt
);
  logic sync1_q, sync2_q, prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= pins[sel];
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    rise = sync2_q & ~prev_q;
    fall = ~sync2_q & prev_q;
    unique case (edge_mode)
      2'b00:   evt = 1'b0;
      2'b01:   evt = rise | fall;
      2'b10:   evt = rise;
      default: evt = fall;
    endcase
  end

  // R3: an edge event needs a change across the last synchronizer stage
  p_edge_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (sync2_q != prev_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import tirq_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt,
  input  logic          allow,
  input  logic          ready,
  output logic          req,
  output logic [IW-1:0] gnt_idx,
  output logic [N-1:0]  acc
);
  logic [N-1:0]        pend_q, pend_d, stay, arrive, gnt;
  logic [N-1:0][N-1:0] old_q, old_d;   // old_q[i][j]: i pending before j

  function automatic logic [N-1:0][N-1:0] order_init();
    logic [N-1:0][N-1:0] m;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        m[i][j] = (i <= j);
    return m;
  endfunction

  always_comb begin
    gnt = '0;
    for (int i = 0; i < N; i++) begin
      gnt[i] = pend_q[i];
      for (int j = 0; j < N; j++)
        gnt[i] = gnt[i] & (~pend_q[j] | old_q[i][j]);
    end
    req = allow & (|pend_q);
    acc = gnt & {N{req & ready}};
    gnt_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) gnt_idx = IW'(i);
  end

  always_comb begin
    stay   = pend_q & ~acc;
    arrive = evt & (~pend_q | acc);
    pend_d = stay | evt;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        if (i == j)                       old_d[i][j] = 1'b1;
        else if (arrive[i] && arrive[j])  old_d[i][j] = (i < j);
        else if (arrive[i])               old_d[i][j] = ~stay[j];
        else if (arrive[j])               old_d[i][j] = stay[i];
        else                              old_d[i][j] = old_q[i][j];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      old_q  <= order_init();
    end else begin
      pend_q <= pend_d;
      old_q  <= old_d;
    end
  end

  // R10/R11: exactly one source is chosen whenever a request is raised
  p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($countones(gnt) == 1));

  genvar g;
  for (g = 0; g < N; g++) begin : g_hold
    // R6: a pending flag survives until its request is accepted
    p_pend_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !acc[g]) |=> pend_q[g]);
  end
endmodule

// File: rtl/tri_irq_ctrl.sv
module tri_irq_ctrl
  import tirq_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int PER_W    = 16,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_we,
  input  logic [7:0]          mode_wdata,
  input  logic                per_we,
  input  logic [PER_W-1:0]    per_wdata,
  input  logic                pin_we,
  input  logic [PIN_W-1:0]    pin_wdata,
  input  logic                lock_set,
  input  logic                lock_clr,
  input  logic [NUM_PINS-1:0] pins_in,
  input  logic                strm_rollover,
  input  logic                strm_wrap,
  input  logic                jmp_valid,
  input  logic [8:0]          jmp_target,
  input  logic                ins_ready,
  output logic                ins_req,
  output logic [1:0]          ins_src,
  output logic [8:0]          ins_link_addr,
  output logic [8:0]          ins_tgt_addr
);
  mode_t              mode_q, mode_d;
  logic [PIN_W-1:0]   pin_q, pin_d;
  logic               lock_q, lock_d;
  logic               strm_evt, pin_evt, tmr_fire;
  logic [NSRC-1:0]    evt, acc, lk_bits;
  logic [IDX_W-1:0]   gnt_idx;
  logic               arb_req, ret_hit, arm, drop;

  irq_pin_edge #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_pin (
    .clk(clk), .rst_n(rst_n), .pins(pins_in), .sel(pin_q),
    .edge_mode(mode_q.p_sel), .evt(pin_evt));

  irq_timer #(.PER_W(PER_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(mode_q.t_en), .per_we(per_we),
    .per_wdata(per_wdata), .fire(tmr_fire));

  irq_arbiter #(.N(NSRC), .IW(IDX_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .evt(evt), .allow(~lock_q), .ready(ins_ready),
    .req(arb_req), .gnt_idx(gnt_idx), .acc(acc));

  always_comb begin
    strm_evt = mode_q.s_sel[1] & (mode_q.s_sel[0] ? strm_wrap : strm_rollover);
    evt      = {tmr_fire, pin_evt, strm_evt};
    lk_bits  = {mode_q.lk_t, mode_q.lk_p, mode_q.lk_s};
    arm      = |(acc & lk_bits);
    ret_hit  = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (jmp_target == VEC_BASE + ADDR_W'(2 * k)) ret_hit = jmp_valid;
    drop     = lock_clr | ret_hit;
    lock_d   = (lock_q & ~drop) | lock_set | arm;
    mode_d   = mode_we ? mode_t'(mode_wdata) : mode_q;
    pin_d    = pin_we ? pin_wdata : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pin_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pin_q  <= pin_d;
      lock_q <= lock_d;
    end
  end

  always_comb begin
    ins_req       = arb_req;
    ins_src       = gnt_idx;
    ins_link_addr = VEC_BASE + ADDR_W'({gnt_idx, 1'b0});
    ins_tgt_addr  = ins_link_addr | 9'h001;
  end

  // R7: the lock holds back every request
  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !ins_req);
  // R8: a set strobe always leaves the lock set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_set |=> lock_q);
  // R9: a return with nothing setting the lock frees it
  p_ret_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_hit && !lock_set && !arm) |=> !lock_q);
  // R5: target register follows the link register of the same pair
  p_vec_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req |-> (ins_tgt_addr == ins_link_addr + 9'd1));
endmodule

// File: tb/test_tri_irq_ctrl.sv
module test_tri_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_we, per_we, pin_we, lock_set, lock_clr;
  logic [7:0]  mode_wdata;
  logic [15:0] per_wdata;
  logic [2:0]  pin_wdata;
  logic [7:0]  pins_in;
  logic        strm_rollover, strm_wrap, jmp_valid, ins_ready;
  logic [8:0]  jmp_target;
  logic        ins_req;
  logic [1:0]  ins_src;
  logic [8:0]  ins_link_addr, ins_tgt_addr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tri_irq_ctrl i_tri_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .per_we(per_we), .per_wdata(per_wdata), .pin_we(pin_we), .pin_wdata(pin_wdata),
    .lock_set(lock_set), .lock_clr(lock_clr), .pins_in(pins_in),
    .strm_rollover(strm_rollover), .strm_wrap(strm_wrap), .jmp_valid(jmp_valid),
    .jmp_target(jmp_target), .ins_ready(ins_ready), .ins_req(ins_req),
    .ins_src(ins_src), .ins_link_addr(ins_link_addr), .ins_tgt_addr(ins_tgt_addr));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] m);
    mode_wdata = m; mode_we = 1'b1; step(); mode_we = 1'b0;
  endtask

  task automatic write_pin(input int idx);
    pin_wdata = 3'(idx); pin_we = 1'b1; step(); pin_we = 1'b0;
  endtask

  task automatic pulse_roll();
    strm_rollover = 1'b1; step(); strm_rollover = 1'b0;
  endtask

  task automatic jump_to(input logic [8:0] t);
    jmp_target = t; jmp_valid = 1'b1; step(); jmp_valid = 1'b0;
  endtask

  task automatic drain();
    ins_ready = 1'b1; step(); step(); ins_ready = 1'b0;
  endtask

  task automatic check_vec(input string tag, input int src);
    check({tag, " src"}, ins_src, src);
    check({tag, " link"}, ins_link_addr, 'h1F0 + 2 * src);
    check({tag, " tgt"}, ins_tgt_addr, 'h1F1 + 2 * src);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_we = 0; per_we = 0; pin_we = 0; lock_set = 0; lock_clr = 0;
    mode_wdata = 0; per_wdata = 0; pin_wdata = 0; pins_in = 0;
    strm_rollover = 0; strm_wrap = 0; jmp_valid = 0; jmp_target = 0; ins_ready = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: reset state and disabled sources
    check("R1 req after reset", ins_req, 0);
    strm_rollover = 1; strm_wrap = 1; step(); strm_rollover = 0; strm_wrap = 0;
    check("R1 pulses with zero mode", ins_req, 0);

    // R2 sweep over streamer select and pulse kind; R5 vector pair
    for (int ss = 0; ss < 4; ss++)
      for (int ev = 0; ev < 2; ev++) begin
        int exp;
        write_mode(8'(ss << 5));
        if (ev == 0) strm_rollover = 1; else strm_wrap = 1;
        step(); strm_rollover = 0; strm_wrap = 0;
        exp = ((ss == 2 && ev == 0) || (ss == 3 && ev == 1)) ? 1 : 0;
        check("R2 streamer select", ins_req, exp);
        if (exp == 1) check_vec("R5 streamer", 0);
        ins_ready = 1; step(); ins_ready = 0;
        check("R6 cleared on accept", ins_req, 0);
      end
    write_mode(8'h00);

    // R3 sweep over pin index, edge mode and direction
    for (int q = 0; q < 3; q++)
      for (int pm = 0; pm < 4; pm++)
        for (int dir = 0; dir < 2; dir++) begin
          int idx, exp, other;
          idx = (q == 0) ? 0 : (q == 1) ? 3 : 7;
          other = (idx + 1) % 8;
          write_mode(8'h00);
          pins_in = (dir == 1) ? 8'hFF : 8'h00;
          write_pin(idx);
          repeat (4) step();
          write_mode(8'(pm << 2));
          pins_in[idx] = ~pins_in[idx];
          step(); check("R3 latency edge1", ins_req, 0);
          step(); check("R3 latency edge2", ins_req, 0);
          step();
          exp = (pm == 1 || (pm == 2 && dir == 0) || (pm == 3 && dir == 1)) ? 1 : 0;
          check("R3 edge mode", ins_req, exp);
          if (exp == 1) check_vec("R5 pin", 1);
          drain();
          pins_in[other] = ~pins_in[other];
          repeat (3) step();
          check("R3 unselected pin", ins_req, 0);
        end
    write_mode(8'h00);
    pins_in = 8'h00;
    repeat (4) step();

    // R4 timer sweep over small periods
    for (int p = 0; p < 7; p++) begin
      int pe;
      pe = (p == 0) ? 1 : p;
      per_wdata = 16'(p); per_we = 1; mode_wdata = 8'h01; mode_we = 1; ins_ready = 1;
      step(); per_we = 0; mode_we = 0;
      for (int n = 1; n <= 3 * pe + 2; n++) begin
        step();
        check("R4 timer period", ins_req, (n % pe == 0) ? 1 : 0);
        if (ins_req) check_vec("R5 timer", 2);
      end
      write_mode(8'h00);
      drain();
    end
    // R12: period rewrite while running restarts the count
    per_wdata = 16'd10; per_we = 1; mode_wdata = 8'h01; mode_we = 1; ins_ready = 1;
    step(); per_we = 0; mode_we = 0;
    repeat (4) step();
    per_wdata = 16'd3; per_we = 1; step(); per_we = 0;
    check("R12 period rewrite", ins_req, 0);
    step(); check("R12 period rewrite", ins_req, 0);
    step(); check("R12 period rewrite", ins_req, 0);
    step(); check("R12 new period tick", ins_req, 1);
    write_mode(8'h00);
    drain();

    // R12: pin index rewrite while rising-edge mode stays enabled
    write_pin(2);
    repeat (4) step();
    write_mode(8'h08);
    pins_in[2] = 1; repeat (3) step();
    check("R12 pin 2 rise", ins_req, 1);
    drain();
    pins_in[2] = 0; repeat (3) step();
    write_pin(5);
    repeat (3) step();
    check("R12 switch no event", ins_req, 0);
    pins_in[2] = 1; repeat (3) step();
    check("R12 old pin ignored", ins_req, 0);
    pins_in[5] = 1; repeat (3) step();
    check("R12 new pin rise", ins_req, 1);
    drain();
    write_mode(8'h00);
    pins_in = 8'h00;
    write_pin(0);
    repeat (4) step();

    // R10: all three sources become pending on one edge
    per_wdata = 16'd20; per_we = 1; mode_wdata = 8'h45; mode_we = 1; ins_ready = 0;
    step(); per_we = 0; mode_we = 0;
    for (int n = 1; n <= 20; n++) begin
      step();
      if (n == 17) pins_in[0] = 1;
      if (n == 19) strm_rollover = 1;
      if (n == 20) strm_rollover = 0;
    end
    check("R10 first streamer", ins_src, 0);
    check("R10 req", ins_req, 1);
    ins_ready = 1;
    step(); check("R10 second pin", ins_src, 1);
    step(); check("R10 third timer", ins_src, 2);
    ins_ready = 0;
    write_mode(8'h00);
    drain();
    pins_in = 8'h00;
    repeat (4) step();

    // R11: older pin event beats newer streamer event
    write_mode(8'h44);
    pins_in[0] = 1; repeat (3) step();
    pulse_roll();
    check("R11 older pin first", ins_src, 1);
    ins_ready = 1; step(); ins_ready = 0;
    check("R11 then streamer", ins_src, 0);
    check("R11 req", ins_req, 1);
    drain();
    write_mode(8'h00);
    pins_in = 8'h00;
    repeat (4) step();

    // R6: a pending event waits while the pipeline is not ready
    write_mode(8'h40);
    pulse_roll();
    repeat (5) step();
    check("R6 held pending", ins_req, 1);
    ins_ready = 1; step(); ins_ready = 0;
    check("R6 accepted", ins_req, 0);

    // R7: no lock-on-entry bit, back-to-back service
    ins_ready = 1;
    pulse_roll(); step();
    pulse_roll();
    check("R7 no lock without L", ins_req, 1);
    step();

    // R7 and R9: lock-on-entry and automatic release
    write_mode(8'hC0);
    pulse_roll();
    check("R7 request before lock", ins_req, 1);
    step();
    pulse_roll();
    check("R7 locked after entry", ins_req, 0);
    jump_to(9'h1F1);
    check("R9 odd target keeps lock", ins_req, 0);
    jump_to(9'h1F0);
    check("R9 return 0x1F0 frees", ins_req, 1);
    step();
    check("R7 relocked", ins_req, 0);
    jump_to(9'h1F4);
    check("R9 return 0x1F4 no pending", ins_req, 0);
    pulse_roll();
    check("R9 free after 0x1F4", ins_req, 1);
    // same edge: return jump and accept of a locking source
    jmp_target = 9'h1F0; jmp_valid = 1; step(); jmp_valid = 0;
    pulse_roll();
    check("R8 entry lock beats return", ins_req, 0);
    lock_clr = 1; step(); lock_clr = 0;
    check("R8 clear strobe frees", ins_req, 1);
    step();
    lock_clr = 1; step(); lock_clr = 0;
    ins_ready = 0;

    // R8: explicit strobes
    write_mode(8'h40);
    lock_set = 1; step(); lock_set = 0;
    pulse_roll();
    check("R8 set strobe blocks", ins_req, 0);
    lock_clr = 1; step(); lock_clr = 0;
    check("R8 clear strobe", ins_req, 1);
    lock_set = 1; lock_clr = 1; step(); lock_set = 0; lock_clr = 0;
    check("R8 set wins over clear", ins_req, 0);
    lock_clr = 1; step(); lock_clr = 0;
    check("R8 released", ins_req, 1);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule